// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt requests and presents two request lines to a processor: a normal line and a fast line. Software routes each source to one of the two lines, enables or disables it by writing its number to one of two command registers, and gives it a 4-bit priority. A threshold register holds back normal requests whose priority is not high enough.

For normal requests the block picks one winning source and reports its number in a status word. For fast requests it reports the highest-numbered pending fast source. A 64-word table of vector words, one per source, sits in the register space so that a handler can index it with the reported number. All control and status is reached over a simple 32-bit register bus with one-cycle read latency. The request lines and both status words follow the source inputs combinationally.

Top module: `vec_intc`

## Requirements
- R1: After reset the mode register (0x00) reads 0, the threshold (0x04) reads 0x1F, every source is disabled and typed normal, every priority is 0, every vector word is 0, both request outputs are low, the normal status (0x40) reads 0xFFFF0000 and the fast status (0x44) reads 0xFFFFFFFF.
- R2: A write to 0x08 sets the enable of the source numbered by write data bits 5:0, and a write to 0x0C clears it. Upper data bits are ignored and no other source's enable changes.
- R3: Register 0x10 holds the type bits of sources 63 down to 32 (bit k is source 32+k) and 0x14 those of sources 31 down to 0 (bit k is source k). A 0 routes the source to the normal line and a 1 routes it to the fast line. Both read back as written.
- R4: Priority registers sit at 0x20 + 4i for i = 0..7. The 4-bit priority of source n is bits (n mod 8)*4+3 down to (n mod 8)*4 of register i = 7 − (n div 8). All eight read back as written.
- R5: Among sources that are raised, enabled and typed normal, the one with the highest priority wins, and among equal priorities the higher source number wins. The status word at 0x40 carries the winner's number in bits 31:16 and zero in bits 15:0. When nothing qualifies, bits 31:16 are 0xFFFF.
- R6: The normal output is high exactly when a normal winner exists and either the threshold (0x04, 5 bits) equals 0x1F or the winner's priority is strictly greater than the threshold.
- R7: The fast output is high exactly when some raised, enabled, fast-typed source exists. The word at 0x44 holds the highest-numbered such source, or 0xFFFFFFFF when there is none. Fast-typed sources never take part in normal arbitration.
- R8: The vector word of source n is read and written at 0x100 + 4n.
- R9: Read data appears on the cycle after the read strobe and holds until the next read. The command registers 0x08 and 0x0C, and any unmapped address, read as 0. Only bit 0 of the mode register is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| src_i | input | 64 | Level-sensitive interrupt requests |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
Arbitration is tried in several ways. Two sources with equal priority separate the tie rule from a plain first-found scan. A single raised source checks the register packing of one priority field, and writes that carry junk in their upper data bits show that the command decode keeps only the source number. Thresholds just above, equal to and below the winning priority, plus the 0x10..0x1E band and the 0x1F value, separate a strict comparison from an inclusive one and from the pass-all case. Long runs of empty, one-hot, sparse and dense request patterns over random types, enables and priorities check both status words and both lines against a model of the requirements, so a source counted on the wrong line or picked by the wrong rule shows up.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
    // Word indices (byte address >> 2) of the register map
    localparam int W_MODE    = 0;
    localparam int W_THRESH  = 1;
    localparam int W_EN_NUM  = 2;
    localparam int W_DIS_NUM = 3;
    localparam int W_TYPE0   = 4;    // first type word covers the upper sources
    localparam int W_PRIO0   = 8;    // first priority word covers the upper sources
    localparam int W_NSTAT   = 16;
    localparam int W_FSTAT   = 17;   // byte offset 0x44
    localparam int W_VEC0    = 64;   // byte offset 0x100
endpackage

// File: rtl/vec_intc_regs.sv
module vec_intc_regs
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 9,
    localparam int ID_W   = $clog2(NUM_SRC),
    localparam int MASK_W = PRIO_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      rd,
    output logic [DATA_W-1:0]         rdata,
    input  logic [DATA_W-1:0]         norm_stat,
    input  logic [DATA_W-1:0]         fast_stat,
    output logic [MASK_W-1:0]         thr_q,
    output logic [NUM_SRC-1:0]        en_q,
    output logic [NUM_SRC-1:0]        fast_q,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
    localparam int PER_REG   = DATA_W / PRIO_W;
    localparam int NPRIO_REG = NUM_SRC / PER_REG;
    localparam int NTYPE_REG = NUM_SRC / DATA_W;

    logic                mode_q;
    logic [DATA_W-1:0]   prio_q [NPRIO_REG];
    logic [DATA_W-1:0]   vec_q  [NUM_SRC];
    logic [DATA_W-1:0]   rmux;
    logic [ID_W-1:0]     vec_idx;
    logic                in_vec;
    int                  wa_i;
    logic                unused_low;

    assign unused_low = ^addr[1:0];

    always_comb begin
        wa_i    = int'(addr[ADDR_W-1:2]);
        in_vec  = (wa_i >= W_VEC0) && (wa_i < W_VEC0 + NUM_SRC);
        vec_idx = ID_W'(wa_i - W_VEC0);
    end

    // Unpack each source's priority field from the reversed register order
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_unpack
        assign prio_flat[n*PRIO_W +: PRIO_W] =
            prio_q[NPRIO_REG-1-(n/PER_REG)][(n%PER_REG)*PRIO_W +: PRIO_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            thr_q  <= '1;
            en_q   <= '0;
            fast_q <= '0;
            for (int p = 0; p < NPRIO_REG; p++) prio_q[p] <= '0;
            for (int v = 0; v < NUM_SRC; v++)   vec_q[v]  <= '0;
        end else if (wr) begin
            if (wa_i == W_MODE)    mode_q <= wdata[0];
            if (wa_i == W_THRESH)  thr_q  <= wdata[MASK_W-1:0];
            if (wa_i == W_EN_NUM)  en_q[wdata[ID_W-1:0]] <= 1'b1;
            if (wa_i == W_DIS_NUM) en_q[wdata[ID_W-1:0]] <= 1'b0;
            for (int t = 0; t < NTYPE_REG; t++) begin
                if (wa_i == W_TYPE0 + t)
                    fast_q[(NTYPE_REG-1-t)*DATA_W +: DATA_W] <= wdata;
            end
            for (int p = 0; p < NPRIO_REG; p++) begin
                if (wa_i == W_PRIO0 + p) prio_q[p] <= wdata;
            end
            if (in_vec) vec_q[vec_idx] <= wdata;
        end
    end

    always_comb begin
        rmux = '0;
        if (wa_i == W_MODE)   rmux = DATA_W'(mode_q);
        if (wa_i == W_THRESH) rmux = DATA_W'(thr_q);
        if (wa_i == W_NSTAT)  rmux = norm_stat;
        if (wa_i == W_FSTAT)  rmux = fast_stat;
        for (int t = 0; t < NTYPE_REG; t++) begin
            if (wa_i == W_TYPE0 + t)
                rmux = fast_q[(NTYPE_REG-1-t)*DATA_W +: DATA_W];
        end
        for (int p = 0; p < NPRIO_REG; p++) begin
            if (wa_i == W_PRIO0 + p) rmux = prio_q[p];
        end
        if (in_vec) rmux = vec_q[vec_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rmux;
    end
endmodule

// File: rtl/vec_intc_norm_arb.sv
module vec_intc_norm_arb #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      valid,
    output logic [ID_W-1:0]           win_id,
    output logic [PRIO_W-1:0]         win_prio
);
    // Ascending scan with >=: a later (higher-numbered) equal priority wins
    always_comb begin
        valid    = 1'b0;
        win_id   = '0;
        win_prio = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (req[n] && (!valid || prio_flat[n*PRIO_W +: PRIO_W] >= win_prio)) begin
                valid    = 1'b1;
                win_id   = ID_W'(n);
                win_prio = prio_flat[n*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/vec_intc_fast_pick.sv
module vec_intc_fast_pick #(
    parameter int NUM_SRC = 64,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               valid,
    output logic [ID_W-1:0]    top_id
);
    always_comb begin
        valid  = 1'b0;
        top_id = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (req[n]) begin
                valid  = 1'b1;
                top_id = ID_W'(n);
            end
        end
    end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int ID_W   = $clog2(NUM_SRC);
    localparam int MASK_W = PRIO_W + 1;
    localparam int HALF_W = DATA_W / 2;

    logic [MASK_W-1:0]         thr_q;
    logic [NUM_SRC-1:0]        en_q;
    logic [NUM_SRC-1:0]        fast_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]        pend_norm;
    logic [NUM_SRC-1:0]        pend_fast;
    logic                      norm_valid;
    logic [ID_W-1:0]           norm_id;
    logic [PRIO_W-1:0]         norm_prio;
    logic                      fast_valid;
    logic [ID_W-1:0]           fast_id;
    logic [DATA_W-1:0]         norm_stat;
    logic [DATA_W-1:0]         fast_stat;

    vec_intc_regs #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .rd        (bus_rd),
        .rdata     (bus_rdata),
        .norm_stat (norm_stat),
        .fast_stat (fast_stat),
        .thr_q     (thr_q),
        .en_q      (en_q),
        .fast_q    (fast_q),
        .prio_flat (prio_flat)
    );

    assign pend_norm = src_i & en_q & ~fast_q;
    assign pend_fast = src_i & en_q &  fast_q;

    vec_intc_norm_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_narb (
        .req       (pend_norm),
        .prio_flat (prio_flat),
        .valid     (norm_valid),
        .win_id    (norm_id),
        .win_prio  (norm_prio)
    );

    vec_intc_fast_pick #(.NUM_SRC(NUM_SRC)) u_fpick (
        .req    (pend_fast),
        .valid  (fast_valid),
        .top_id (fast_id)
    );

    assign norm_stat = norm_valid ? {HALF_W'(norm_id), {HALF_W{1'b0}}}
                                  : {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
    assign fast_stat = fast_valid ? DATA_W'(fast_id) : '1;

    assign irq_o = norm_valid && ((thr_q == '1) || ({1'b0, norm_prio} > thr_q));
    assign fiq_o = |pend_fast;
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 9,
    localparam int ID_W   = $clog2(NUM_SRC),
    localparam int MASK_W = PRIO_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] en_q,
    input logic [MASK_W-1:0]  thr_q,
    input logic               norm_valid,
    input logic [PRIO_W-1:0]  norm_prio,
    input logic [DATA_W-1:0]  norm_stat,
    input logic [DATA_W-1:0]  fast_stat
);
    logic is_en_wr, is_dis_wr, is_thr_wr;
    assign is_en_wr  = bus_wr && (int'(bus_addr[ADDR_W-1:2]) == W_EN_NUM);
    assign is_dis_wr = bus_wr && (int'(bus_addr[ADDR_W-1:2]) == W_DIS_NUM);
    assign is_thr_wr = bus_wr && (int'(bus_addr[ADDR_W-1:2]) == W_THRESH);

    p_enable_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_en_wr |=> en_q[$past(bus_wdata[ID_W-1:0])]);

    p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_dis_wr |=> !en_q[$past(bus_wdata[ID_W-1:0])]);

    p_irq_has_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (norm_stat[DATA_W-1:DATA_W/2] != '1));

    p_mask_holds_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_valid && (thr_q != '1) && ({1'b0, norm_prio} <= thr_q)) |-> !irq_o);

    p_thr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !is_thr_wr |=> $stable(thr_q));

    p_fiq_matches_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == (fast_stat != '1));
endmodule

bind vec_intc vec_intc_chk #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .en_q       (en_q),
    .thr_q      (thr_q),
    .norm_valid (norm_valid),
    .norm_prio  (norm_prio),
    .norm_stat  (norm_stat),
    .fast_stat  (fast_stat)
);

// File: tb/test_vec_intc.sv
module test_vec_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] src = '0;
    logic        irq_o, fiq_o;

    always #10 clk = ~clk;   // 50 MHz

    vec_intc i_vec_intc (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .src_i(src), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Shadow state built from the requirements
    logic        sh_mode = 1'b0;
    logic [4:0]  sh_thr  = 5'h1f;
    logic [63:0] sh_en   = '0;
    logic [63:0] sh_fast = '0;
    logic [3:0]  sh_prio [64];
    logic [31:0] sh_vec  [64];

    // Scoreboard queues
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        mon_due = 1'b0;

    function automatic void m_norm(output bit v, output int id, output int bp);
        v = 0; id = 0; bp = 0;
        for (int n = 0; n < 64; n++)
            if (src[n] && sh_en[n] && !sh_fast[n] && (!v || int'(sh_prio[n]) >= bp)) begin
                v = 1; id = n; bp = int'(sh_prio[n]);
            end
    endfunction

    function automatic logic m_irq();
        bit v; int id; int bp;
        m_norm(v, id, bp);
        return v && (sh_thr == 5'h1f || bp > int'(sh_thr));
    endfunction

    function automatic logic [31:0] m_fstat();
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int n = 0; n < 64; n++)
            if (src[n] && sh_en[n] && sh_fast[n]) r = 32'(n);
        return r;
    endfunction

    function automatic logic [31:0] m_reg(input logic [8:0] a);
        int w = int'(a[8:2]);
        bit v; int id; int bp;
        logic [31:0] r = '0;
        if (w == 0) r = {31'b0, sh_mode};
        else if (w == 1) r = {27'b0, sh_thr};
        else if (w == 4) r = sh_fast[63:32];
        else if (w == 5) r = sh_fast[31:0];
        else if (w >= 8 && w <= 15) begin
            for (int k = 0; k < 8; k++) r[k*4 +: 4] = sh_prio[(7-(w-8))*8 + k];
        end else if (w == 16) begin
            m_norm(v, id, bp);
            r = v ? {id[15:0], 16'h0} : 32'hFFFF_0000;
        end else if (w == 17) r = m_fstat();
        else if (w >= 64) r = sh_vec[w-64];
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic pins(input string tag);
        check({tag, " irq"}, {31'b0, irq_o}, {31'b0, m_irq()});
        check({tag, " fiq"}, {31'b0, fiq_o}, {31'b0, |(src & sh_en & sh_fast)});
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        int w = int'(a[8:2]);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (w == 0) sh_mode = d[0];
        else if (w == 1) sh_thr = d[4:0];
        else if (w == 2) sh_en[d[5:0]] = 1'b1;
        else if (w == 3) sh_en[d[5:0]] = 1'b0;
        else if (w == 4) sh_fast[63:32] = d;
        else if (w == 5) sh_fast[31:0] = d;
        else if (w >= 8 && w <= 15) begin
            for (int k = 0; k < 8; k++) sh_prio[(7-(w-8))*8 + k] = d[k*4 +: 4];
        end else if (w >= 64) sh_vec[w-64] = d;
    endtask

    // Driver: issue a read and push its expected value
    task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src = v;
        #1;
    endtask

    // Monitor: pop and compare one cycle after each read strobe
    always @(posedge clk) mon_due <= bus_rd;
    always @(negedge clk) begin
        if (mon_due) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R9: read data with no expected item actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        for (int n = 0; n < 64; n++) begin sh_prio[n] = '0; sh_vec[n] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all sources raised but none enabled
        set_src('1);
        pins("R1 reset");
        rd(9'h000, 32'h0,         "R1 mode");
        rd(9'h004, 32'h1f,        "R1 threshold");
        rd(9'h010, 32'h0,         "R1 type hi");
        rd(9'h014, 32'h0,         "R1 type lo");
        rd(9'h03C, 32'h0,         "R1 prio");
        rd(9'h040, 32'hFFFF0000,  "R1 normal status");
        rd(9'h044, 32'hFFFFFFFF,  "R1 fast status");
        rd(9'h1FC, 32'h0,         "R1 vector 63");

        // R9: mode bit 0 only, command regs and holes read 0, data holds
        wr(9'h000, 32'hFFFF_FFFF);
        rd(9'h000, 32'h1,         "R9 mode bit only");
        wr(9'h008, 32'd3);
        rd(9'h008, 32'h0,         "R9 enable cmd reads 0");
        rd(9'h00C, 32'h0,         "R9 disable cmd reads 0");
        rd(9'h080, 32'h0,         "R9 unmapped reads 0");
        wr(9'h00C, 32'd3);
        rd(9'h004, 32'h1f,        "R9 hold source");
        @(negedge clk); @(negedge clk);
        check("R9 rdata held", bus_rdata, 32'h1f);

        // R8: vector table
        wr(9'h100, 32'hA5A5_0000);
        wr(9'h100 + 9'(4*37), 32'h1234_5678);
        wr(9'h1FC, 32'hDEAD_BEEF);
        rd(9'h100, 32'hA5A5_0000, "R8 vector 0");
        rd(9'h194, 32'h1234_5678, "R8 vector 37");
        rd(9'h1FC, 32'hDEAD_BEEF, "R8 vector 63");

        // R2/R5: tie between sources 5 and 40 at priority 3
        set_src(64'h0);
        wr(9'h008, 32'hFFFF_FFC5);        // bits 5:0 = 5
        wr(9'h008, 32'd40);
        wr(9'h03C, 32'h0030_0000);        // source 5: reg 7, bits 23:20
        wr(9'h028, 32'h0000_0003);        // source 40: reg 2, bits 3:0
        set_src((64'd1 << 5) | (64'd1 << 40));
        pins("R2 two enabled");
        rd(9'h040, {16'd40, 16'h0}, "R5 tie goes to higher number");
        wr(9'h00C, 32'hFFFF_FF28);        // bits 5:0 = 40
        rd(9'h040, {16'd5, 16'h0},  "R2 disable leaves source 5");

        // R4: priority of source 9 at reg 6 (0x38), bits 7:4
        wr(9'h008, 32'd9);
        wr(9'h038, 32'h0000_00F0);
        set_src((64'd1 << 5) | (64'd1 << 9));
        rd(9'h040, {16'd9, 16'h0},  "R4 packed priority wins");
        rd(9'h038, 32'h0000_00F0,   "R4 read back");

        // R6: threshold around winner priority 15
        wr(9'h004, 32'd15); pins("R6 thr equal");
        check("R6 thr equal holds off", {31'b0, irq_o}, 32'h0);
        wr(9'h004, 32'd14);
        check("R6 thr below passes", {31'b0, irq_o}, 32'h1);
        wr(9'h004, 32'h10);
        check("R6 band masks all", {31'b0, irq_o}, 32'h0);
        wr(9'h004, 32'h1f);
        check("R6 all-ones passes", {31'b0, irq_o}, 32'h1);

        // R3/R7: routing to the fast line
        wr(9'h008, 32'd40);
        wr(9'h010, 32'h0000_0100);        // source 40 fast
        set_src((64'd1 << 5) | (64'd1 << 9) | (64'd1 << 40));
        pins("R7 fast source");
        rd(9'h044, 32'd40,          "R7 fast status");
        rd(9'h040, {16'd9, 16'h0},  "R7 fast excluded from normal");
        wr(9'h014, 32'h0000_0020);        // source 5 fast too
        rd(9'h044, 32'd40,          "R7 highest-numbered fast");
        rd(9'h010, 32'h0000_0100,   "R3 type hi read back");
        rd(9'h014, 32'h0000_0020,   "R3 type lo read back");

        // Random runs against the model (R2..R7)
        for (int it = 0; it < 400; it++) begin
            int sel = $urandom_range(0, 7);
            if (sel == 0) wr(9'h008, 32'($urandom_range(0, 63)));
            if (sel == 1) wr(9'h00C, 32'($urandom_range(0, 63)));
            if (sel == 2) wr(9'(9'h010 + 4*$urandom_range(0, 1)), $urandom & $urandom);
            if (sel == 3) wr(9'(9'h020 + 4*$urandom_range(0, 7)), $urandom);
            if (sel == 4) wr(9'h004, 32'($urandom_range(0, 31)));
            if (sel == 5) wr(9'h004, 32'h1f);
            case ($urandom_range(0, 3))
                0: set_src('0);
                1: set_src(64'd1 << $urandom_range(0, 63));
                2: set_src({$urandom, $urandom} & {$urandom, $urandom});
                default: set_src({$urandom, $urandom});
            endcase
            pins("R6/R7 random");
            rd(9'h040, m_reg(9'h040), "R5 random normal status");
            rd(9'h044, m_reg(9'h044), "R7 random fast status");
        end

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R9: reads left unanswered actual=%0d expected=0", exp_q.size());
        end
        summary();
    end
endmodule